// File: doc/BRIEF.md
# PHY interrupt status aggregator

This block gathers event indications from the receive and link logic of an Ethernet transceiver into a 16-bit sticky interrupt status word. Management software reads the word through a read strobe. The same access that returns the value also clears every bit. An event that arrives in the cycle of that read is kept, so it is not lost.

Three event counters track disconnects, false carriers and receive errors. The disconnect and receive-error counters wrap. The false-carrier counter stops at its maximum. Each counter posts a warning bit in the status word when its most significant bit goes from 0 to 1, which gives software time to read it before it overflows. Reading a counter clears it.

A small symbol-stream monitor flags a 100 Mb/s frame that ends early. An active-high interrupt line stays asserted while any enabled status bit is set.

Top module: `phy_irq_aggregator`

## Requirements
- R1: After reset, the status word, all three counters and the irq output are 0.
- R2: When `stat_rd` is high in a cycle, `stat` shows the bits for that cycle. In the next cycle every bit that had no new event is 0. Without a read, set bits stay set.
- R3: An event in the same cycle as a status read leaves its bit set after the read.
- R4: A pulse on `link_unstable` sets bit 15. A pulse on `misc_evt[i]` sets bit i+1 for i = 0..6. Bit 0 always reads 0. Each bit is visible in the cycle after the pulse.
- R5: Any rising or falling edge of `link_up` sets bit 14. Any edge of `dscr_lock` sets bit 13. Edges are taken against the value in the previous cycle, and that value is 0 after reset.
- R6: When `fast_mode` is 1, symbols with `sym_vld` high are decoded from `sym_kind` as 0 = data, 1 = idle, 2 = start delimiter, 3 = end delimiter. Two idle symbols in a row inside a frame, with no end delimiter before them, set bit 12 and close the frame. Data resets the idle run. An end delimiter closes the frame without setting the bit.
- R7: When `fast_mode` is 0, bit 12 never sets and no frame is tracked.
- R8: Each of `disc_evt`, `fcar_evt` and `rxerr_evt` adds one to its CNT_W-bit counter. The disconnect and receive-error counters wrap from all-ones to 0. The false-carrier counter holds at all-ones.
- R9: Bits 11, 10 and 9 set when the MSB of the disconnect, false-carrier and receive-error counter, in that order, goes from 0 to 1. They do not set again while the MSB stays 1.
- R10: A read strobe on a counter clears it to 0. An event in the same cycle is counted after the clear, so the counter then reads 1.
- R11: `irq` is high exactly while `stat & irq_enable` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_unstable | input | 1 | Unstable-link pulse from the carrier monitor |
| link_up | input | 1 | Current link level |
| dscr_lock | input | 1 | Current descrambler lock level |
| misc_evt | input | 7 | Pulses for the lower event bits 7..1 |
| fast_mode | input | 1 | 1 when running at 100 Mb/s |
| sym_vld | input | 1 | Symbol valid |
| sym_kind | input | 2 | Symbol class |
| disc_evt | input | 1 | Disconnect event pulse |
| fcar_evt | input | 1 | False-carrier event pulse |
| rxerr_evt | input | 1 | Receive-error event pulse |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| disc_rd | input | 1 | Disconnect counter read strobe |
| fcar_rd | input | 1 | False-carrier counter read strobe |
| rxerr_rd | input | 1 | Receive-error counter read strobe |
| irq_enable | input | 16 | Interrupt mask, 1 enables a bit |
| stat | output | 16 | Status word |
| disc_cnt | output | CNT_W | Disconnect count |
| fcar_cnt | output | CNT_W | False-carrier count |
| rxerr_cnt | output | CNT_W | Receive-error count |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong edge register or a wrong frame state shows up as a status bit that is missing or extra one cycle after the stimulus. The per-cycle model catches it at the next sample. A counter that wraps or saturates in the wrong place, or that warns twice, differs from the model on its count port or on bits 11 to 9 right at that boundary, which is reached within about 300 events. A clear that drops a same-cycle event leaves `stat` or a counter one value short in the cycle after the read.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int STAT_W   = 16;
  localparam int MISC_N   = 7;
  localparam int B_UNST   = 15;
  localparam int B_LINK   = 14;
  localparam int B_LOCK   = 13;
  localparam int B_EARLY  = 12;
  localparam int B_DISC   = 11;
  localparam int B_FCAR   = 10;
  localparam int B_RXERR  = 9;
  localparam int B_MISC0  = 1;

  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_IDLE = 2'd1,
    SYM_SSD  = 2'd2,
    SYM_ESD  = 2'd3
  } sym_kind_e;
endpackage

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         msb_rise
);
  localparam int MSB = W - 1;

  logic [W-1:0] cnt_q, cnt_d, base;
  logic         en;

  assign en   = inc | clr;
  assign base = clr ? '0 : cnt_q;

  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        if (!clr && (&cnt_q)) cnt_d = cnt_q;
        else                  cnt_d = base + W'(inc);
      end
    end else begin : g_roll
      always_comb cnt_d = base + W'(inc);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign msb_rise = en & cnt_d[MSB] & ~cnt_q[MSB];
  assign cnt      = cnt_q;

  generate
    if (SATURATE) begin : g_sat_chk
      assert_saturate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !clr) |=> (&cnt_q));
    end else begin : g_roll_chk
      assert_rollover_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && inc && !clr) |=> (cnt_q == '0));
    end
  endgenerate

  assert_warn_msb_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msb_rise |=> cnt_q[MSB]);

  assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_early_end.sv
module irq_early_end
  import phy_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       sym_vld,
  input  logic [1:0] sym_kind,
  output logic       early_end
);
  logic in_q, in_d, idle_q, idle_d;
  sym_kind_e kind;

  assign kind = sym_kind_e'(sym_kind);

  always_comb begin
    in_d      = in_q;
    idle_d    = idle_q;
    early_end = 1'b0;
    if (!fast_mode) begin
      in_d   = 1'b0;
      idle_d = 1'b0;
    end else if (sym_vld) begin
      unique case (kind)
        SYM_SSD: begin
          in_d   = 1'b1;
          idle_d = 1'b0;
        end
        SYM_ESD: begin
          in_d   = 1'b0;
          idle_d = 1'b0;
        end
        SYM_IDLE: begin
          if (in_q) begin
            if (idle_q) begin
              early_end = 1'b1;
              in_d      = 1'b0;
              idle_d    = 1'b0;
            end else begin
              idle_d = 1'b1;
            end
          end
        end
        default: idle_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      idle_q <= idle_d;
    end
  end

  assert_early_closes_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    early_end |=> !in_q);

  assert_slow_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_mode |=> !in_q);
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd_clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q, stat_d;
  logic         en;

  assign en     = rd_clr | (|set_vec);
  assign stat_d = (rd_clr ? '0 : stat_q) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stat_q <= '0;
    else if (en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set_vec == '0)) |=> (stat_q == '0));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_event_survives_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/phy_irq_aggregator.sv
module phy_irq_aggregator
  import phy_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_unstable,
  input  logic                  link_up,
  input  logic                  dscr_lock,
  input  logic [MISC_N-1:0]     misc_evt,
  input  logic                  fast_mode,
  input  logic                  sym_vld,
  input  logic [1:0]            sym_kind,
  input  logic                  disc_evt,
  input  logic                  fcar_evt,
  input  logic                  rxerr_evt,
  input  logic                  stat_rd,
  input  logic                  disc_rd,
  input  logic                  fcar_rd,
  input  logic                  rxerr_rd,
  input  logic [STAT_W-1:0]     irq_enable,
  output logic [STAT_W-1:0]     stat,
  output logic [CNT_W-1:0]      disc_cnt,
  output logic [CNT_W-1:0]      fcar_cnt,
  output logic [CNT_W-1:0]      rxerr_cnt,
  output logic                  irq
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              link_prev_q, lock_prev_q;
  logic              link_chg, lock_chg;
  logic              early_end;
  logic              disc_warn, fcar_warn, rxerr_warn;
  logic [STAT_W-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      link_prev_q <= 1'b0;
      lock_prev_q <= 1'b0;
    end else begin
      link_prev_q <= link_up;
      lock_prev_q <= dscr_lock;
    end
  end

  assign link_chg = link_up ^ link_prev_q;
  assign lock_chg = dscr_lock ^ lock_prev_q;

  irq_early_end u_early (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fast_mode (fast_mode),
    .sym_vld   (sym_vld),
    .sym_kind  (sym_kind),
    .early_end (early_end)
  );

  irq_evt_counter #(.W(CNT_W), .SATURATE(1'b0)) u_disc (
    .clk (clk), .rst_n (rst_int_n), .inc (disc_evt), .clr (disc_rd),
    .cnt (disc_cnt), .msb_rise (disc_warn)
  );

  irq_evt_counter #(.W(CNT_W), .SATURATE(1'b1)) u_fcar (
    .clk (clk), .rst_n (rst_int_n), .inc (fcar_evt), .clr (fcar_rd),
    .cnt (fcar_cnt), .msb_rise (fcar_warn)
  );

  irq_evt_counter #(.W(CNT_W), .SATURATE(1'b0)) u_rxerr (
    .clk (clk), .rst_n (rst_int_n), .inc (rxerr_evt), .clr (rxerr_rd),
    .cnt (rxerr_cnt), .msb_rise (rxerr_warn)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_UNST]  = link_unstable;
    set_vec[B_LINK]  = link_chg;
    set_vec[B_LOCK]  = lock_chg;
    set_vec[B_EARLY] = early_end;
    set_vec[B_DISC]  = disc_warn;
    set_vec[B_FCAR]  = fcar_warn;
    set_vec[B_RXERR] = rxerr_warn;
    for (int i = 0; i < MISC_N; i++) set_vec[B_MISC0 + i] = misc_evt[i];
  end

  irq_sticky_reg #(.W(STAT_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_vec (set_vec),
    .rd_clr  (stat_rd),
    .stat    (stat)
  );

  assign irq = |(stat & irq_enable);

  assert_link_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_chg |=> stat[B_LINK]);

  assert_lock_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_chg |=> stat[B_LOCK]);

  assert_early_latched_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    early_end |=> stat[B_EARLY]);

  assert_unstable_latched_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_unstable |=> stat[B_UNST]);
endmodule

// File: tb/tb_phy_irq_aggregator.sv
module tb_phy_irq_aggregator;
  localparam int CW  = 8;
  localparam int MAX = (1 << CW) - 1;
  localparam int HALF = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic link_unstable, link_up, dscr_lock, fast_mode, sym_vld;
  logic [6:0] misc_evt;
  logic [1:0] sym_kind;
  logic disc_evt, fcar_evt, rxerr_evt, stat_rd, disc_rd, fcar_rd, rxerr_rd;
  logic [15:0] irq_enable, stat;
  logic [CW-1:0] disc_cnt, fcar_cnt, rxerr_cnt;
  logic irq;

  always #5 clk = ~clk;

  phy_irq_aggregator #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .link_unstable(link_unstable), .link_up(link_up),
    .dscr_lock(dscr_lock), .misc_evt(misc_evt), .fast_mode(fast_mode),
    .sym_vld(sym_vld), .sym_kind(sym_kind), .disc_evt(disc_evt),
    .fcar_evt(fcar_evt), .rxerr_evt(rxerr_evt), .stat_rd(stat_rd),
    .disc_rd(disc_rd), .fcar_rd(fcar_rd), .rxerr_rd(rxerr_rd),
    .irq_enable(irq_enable), .stat(stat), .disc_cnt(disc_cnt),
    .fcar_cnt(fcar_cnt), .rxerr_cnt(rxerr_cnt), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  logic [15:0] m_stat;
  bit m_link, m_lock, m_inf, m_idl;
  int m_dc, m_fc, m_re;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(stat[15] == m_stat[15] && stat[7:0] == m_stat[7:0], "R4 unstable/misc bits",
        int'(stat), int'(m_stat));
    chk(stat[14:13] == m_stat[14:13], "R5 edge bits", int'(stat[14:13]), int'(m_stat[14:13]));
    chk(stat[12] == m_stat[12], "R6 early-end bit", int'(stat[12]), int'(m_stat[12]));
    chk(stat[11:9] == m_stat[11:9], "R9 warn bits", int'(stat[11:9]), int'(m_stat[11:9]));
    chk(int'(disc_cnt) == m_dc && int'(fcar_cnt) == m_fc && int'(rxerr_cnt) == m_re,
        "R8 counters", int'({disc_cnt, fcar_cnt, rxerr_cnt}), (m_dc << 16) | (m_fc << 8) | m_re);
    chk(irq == (|(m_stat & irq_enable)), "R11 irq", int'(irq), int'(|(m_stat & irq_enable)));
  endtask

  task automatic cyc();
    logic [15:0] s;
    bit ninf, nidl;
    int ndc, nfc, nre;
    s = '0;
    s[15] = link_unstable;
    s[7:1] = misc_evt;
    if (link_up != m_link) s[14] = 1'b1;
    if (dscr_lock != m_lock) s[13] = 1'b1;
    ninf = m_inf; nidl = m_idl;
    if (!fast_mode) begin ninf = 0; nidl = 0; end
    else if (sym_vld) begin
      if (sym_kind == 2'd2) begin ninf = 1; nidl = 0; end
      else if (sym_kind == 2'd3) begin ninf = 0; nidl = 0; end
      else if (sym_kind == 2'd1) begin
        if (m_inf) begin
          if (m_idl) begin s[12] = 1'b1; ninf = 0; nidl = 0; end
          else nidl = 1;
        end
      end else nidl = 0;
    end
    ndc = ((disc_rd ? 0 : m_dc) + int'(disc_evt)) % (MAX + 1);
    nre = ((rxerr_rd ? 0 : m_re) + int'(rxerr_evt)) % (MAX + 1);
    if (fcar_rd) nfc = int'(fcar_evt);
    else if (m_fc == MAX) nfc = MAX;
    else nfc = m_fc + int'(fcar_evt);
    if (ndc >= HALF && m_dc < HALF) s[11] = 1'b1;
    if (nfc >= HALF && m_fc < HALF) s[10] = 1'b1;
    if (nre >= HALF && m_re < HALF) s[9] = 1'b1;
    @(posedge clk);
    m_stat = (stat_rd ? 16'h0 : m_stat) | s;
    m_link = link_up; m_lock = dscr_lock; m_inf = ninf; m_idl = nidl;
    m_dc = ndc; m_fc = nfc; m_re = nre;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    link_unstable = 0; misc_evt = '0; sym_vld = 0; sym_kind = 2'd0;
    disc_evt = 0; fcar_evt = 0; rxerr_evt = 0;
    stat_rd = 0; disc_rd = 0; fcar_rd = 0; rxerr_rd = 0;
  endtask

  task automatic read_stat();
    stat_rd = 1; cyc(); stat_rd = 0;
  endtask

  task automatic sym(input logic [1:0] k);
    sym_vld = 1; sym_kind = k; cyc(); sym_vld = 0;
  endtask

  initial begin
    #(10 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; link_up = 0; dscr_lock = 0; fast_mode = 0; irq_enable = 16'hFFFF;
    idle_inputs();
    m_stat = '0; m_link = 0; m_lock = 0; m_inf = 0; m_idl = 0;
    m_dc = 0; m_fc = 0; m_re = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stat == 16'h0 && disc_cnt == 0 && fcar_cnt == 0 && rxerr_cnt == 0 && !irq,
        "R1 reset state", int'(stat), 0);
    rst_n = 1;
    repeat (4) cyc();

    // R4: unstable and misc pulses
    link_unstable = 1; misc_evt = 7'b1010101; cyc();
    idle_inputs(); cyc();
    chk(stat == 16'h80AA, "R4 pattern A", int'(stat), 16'h80AA);
    read_stat();
    chk(stat == 16'h0, "R2 cleared after read", int'(stat), 0);
    misc_evt = 7'b0101010; cyc(); idle_inputs(); cyc();
    read_stat();

    // R5: edges of both level inputs
    link_up = 1; cyc(); cyc();
    dscr_lock = 1; cyc(); read_stat();
    link_up = 0; dscr_lock = 0; cyc(); cyc();
    chk(stat[14:13] == 2'b11, "R5 falling edges", int'(stat[14:13]), 3);
    read_stat();

    // R3: event coincident with read survives
    misc_evt = 7'b0000001; cyc(); idle_inputs();
    link_unstable = 1; stat_rd = 1; cyc(); idle_inputs();
    chk(stat == 16'h8000, "R3 same-cycle event kept", int'(stat), 16'h8000);
    read_stat();

    // R6: early end rule at 100 Mb/s
    fast_mode = 1; cyc();
    sym(2'd2); sym(2'd0); sym(2'd1); sym(2'd0); sym(2'd1); sym(2'd3);
    chk(stat[12] == 1'b0, "R6 normal end no flag", int'(stat[12]), 0);
    sym(2'd1); sym(2'd1);
    chk(stat[12] == 1'b0, "R6 idles outside frame", int'(stat[12]), 0);
    sym(2'd2); sym(2'd0); sym(2'd1); cyc(); sym(2'd1);
    chk(stat[12] == 1'b1, "R6 two idles flag", int'(stat[12]), 1);
    read_stat();

    // R7: no detection in 10 Mb/s mode
    fast_mode = 0; cyc();
    sym(2'd2); sym(2'd0); sym(2'd1); sym(2'd1);
    chk(stat[12] == 1'b0, "R7 slow mode no flag", int'(stat[12]), 0);

    // R8/R9: counters and MSB warnings
    for (int i = 0; i < 130; i++) begin
      disc_evt = 1; fcar_evt = 1; rxerr_evt = (i % 2 == 0); cyc();
    end
    idle_inputs(); cyc();
    chk(stat[11:10] == 2'b11, "R9 warn on MSB rise", int'(stat[11:9]), 6);
    read_stat();
    for (int i = 0; i < 170; i++) begin
      disc_evt = 1; fcar_evt = 1; cyc();
    end
    idle_inputs(); cyc();
    chk(int'(fcar_cnt) == MAX, "R8 false-carrier saturates", int'(fcar_cnt), MAX);
    chk(int'(disc_cnt) == 300 - 256, "R8 disconnect wraps", int'(disc_cnt), 44);
    chk(stat[10] == 1'b0, "R9 no repeat while MSB high", int'(stat[10]), 0);
    for (int i = 0; i < 100; i++) begin
      disc_evt = 1; rxerr_evt = 1; cyc();
    end
    idle_inputs(); cyc();
    read_stat();

    // R10: counter read clears, same-cycle event counted after
    rxerr_rd = 1; rxerr_evt = 1; disc_rd = 1; fcar_rd = 1; cyc(); idle_inputs();
    chk(rxerr_cnt == 1, "R10 read plus event", int'(rxerr_cnt), 1);
    chk(disc_cnt == 0 && fcar_cnt == 0, "R10 read clears", int'({disc_cnt, fcar_cnt}), 0);

    // R11: mask
    irq_enable = 16'h0002; link_unstable = 1; cyc(); idle_inputs(); cyc();
    chk(irq == 1'b0, "R11 masked bit no irq", int'(irq), 0);
    irq_enable = 16'h8000; cyc();
    chk(irq == 1'b1, "R11 enabled bit irq", int'(irq), 1);
    read_stat(); cyc();
    chk(irq == 1'b0, "R11 irq drops after clear", int'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule